// File: doc/BRIEF.md
# Software-Raised Interrupt Flag Bank

This block holds eight interrupt flags that software raises and lowers through register writes. Each flag drives one interrupt request line. The line behaves exactly like a request from a hardware peripheral, so downstream priority and arbitration logic can treat both kinds of source the same way.

The flags are spread over two 32-bit registers, with one flag per byte lane. Each lane has two control bits:

- **Raise bit (bit 6 of the lane).** Writing 1 here sets the flag. The raise bit itself is never stored and always reads 0.
- **Lower bit (bit 7 of the lane).** This bit is the flag. Writing 1 here clears it.

If one write puts 1 in both bits, the flag is set. Writes carry per-lane byte strobes, so each flag can be touched without a read-modify-write. A combinational read port returns the selected register.

Top module: `swirq_flags`

## Requirements
- R1: While reset is asserted, and in the cycle after reset, every flag and every `irq_req` bit is 0.
- R2: Flag n lives in register n/4, byte lane n%4. An enabled write to that register with the lane strobed and bit 6 of the lane at 1 sets the flag on that clock edge.
- R3: An enabled write with the lane strobed, bit 7 of the lane at 1 and bit 6 at 0 clears the flag on that clock edge.
- R4: An enabled write with both bit 6 and bit 7 of the lane at 1 leaves the flag set, whatever its state before.
- R5: A strobed write with both bit 6 and bit 7 of the lane at 0 leaves the flag unchanged.
- R6: A write whose byte strobe for a lane is 0 leaves that lane's flag unchanged, whatever the data.
- R7: A write to one register index leaves every flag of the other register unchanged.
- R8: On `rd_data`, bit 7 of lane l shows flag (`rd_idx`*4 + l). Bit 6 and bits 0 to 5 of every lane read 0.
- R9: `irq_req[n]` equals flag n. It takes its new value in the cycle after the write edge and has no further delay.
- R10: When `wr_en` is 0, no flag changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_idx | input | 1 | Register selected for the write |
| wr_data | input | 32 | Write data, one control byte per lane |
| wr_strb | input | 4 | Byte-lane enables for the write |
| rd_idx | input | 1 | Register selected for read-back |
| rd_data | output | 32 | Read-back word of the selected register |
| irq_req | output | 8 | Interrupt request lines, one per flag |

## Verification
The bench writes 1 to both control bits of a lane, once with the flag clear and once with it already set. A design that gives the lower bit priority would clear the flag instead. It also writes with strobes off and with `wr_en` low while the data carries 1s; a design that ignores the strobe or the enable would disturb flags it must leave alone. It aims writes at the wrong register index and checks that bit 6 always reads 0, which catches a lane-to-flag mapping fault and a raise bit that is stored.

// File: rtl/swirq_pkg.sv
// Package: shared constants for the software interrupt flag bank.
// Assumes byte-lane organisation with 8-bit lanes.
package swirq_pkg;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned SET_POS = 6;  // raise bit inside a lane
    localparam int unsigned CLR_POS = 7;  // flag / lower bit inside a lane
endpackage

// File: rtl/swflag_cell.sv
// Module: one software-controlled flag. Raise wins over lower when both
// are requested in the same write. Assumes hit is a single-cycle qualifier.
module swflag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic raise,
    input  logic lower,
    output logic flag
);
    // Holds the flag; raise has priority over lower.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit && raise) begin
            flag <= 1'b1;
        end else if (hit && lower) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/swflag_rdmux.sv
// Module: builds the read-back word for the selected register.
// Assumes NUM_FLAGS is a multiple of the lane count.
module swflag_rdmux #(
    parameter int unsigned NUM_FLAGS = 8,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned LANES    = DATA_W / swirq_pkg::BYTE_W,
    localparam int unsigned NUM_REGS = NUM_FLAGS / LANES,
    localparam int unsigned IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [DATA_W-1:0]    rd_data
);
    import swirq_pkg::*;

    // Places each flag of the chosen register at the lower-bit position.
    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (rd_idx == IDX_W'(r)) begin
                for (int l = 0; l < LANES; l++) begin
                    rd_data[l*BYTE_W + CLR_POS] = flags[r*LANES + l];
                end
            end
        end
    end
endmodule

// File: rtl/swirq_flags.sv
// Module: bank of software-raised interrupt flags, one per byte lane.
// Assumes single-cycle writes with byte strobes; read is combinational.
module swirq_flags #(
    parameter int unsigned NUM_FLAGS = 8,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned LANES    = DATA_W / swirq_pkg::BYTE_W,
    localparam int unsigned NUM_REGS = NUM_FLAGS / LANES,
    localparam int unsigned IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [LANES-1:0]     wr_strb,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [DATA_W-1:0]    rd_data,
    output logic [NUM_FLAGS-1:0] irq_req
);
    import swirq_pkg::*;

    logic [NUM_FLAGS-1:0] flags;

    // One cell per flag, decoded from its register index and lane.
    for (genvar n = 0; n < NUM_FLAGS; n++) begin : g_flag
        localparam int unsigned REG  = n / LANES;
        localparam int unsigned LANE = n % LANES;
        logic hit;
        // Write reaches this flag's lane.
        assign hit = wr_en && (wr_idx == IDX_W'(REG)) && wr_strb[LANE];
        swflag_cell cell_i (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit),
            .raise (wr_data[LANE*BYTE_W + SET_POS]),
            .lower (wr_data[LANE*BYTE_W + CLR_POS]),
            .flag  (flags[n])
        );
    end

    swflag_rdmux #(
        .NUM_FLAGS (NUM_FLAGS),
        .DATA_W    (DATA_W)
    ) rdmux_i (
        .flags   (flags),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    // Requests mirror the flags directly.
    assign irq_req = flags;
endmodule

// File: rtl/swirq_flags_chk.sv
// Module: property checker for swirq_flags, attached by bind.
// Assumes the same parameters as the checked instance.
module swirq_flags_chk #(
    parameter int unsigned NUM_FLAGS = 8,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned LANES    = DATA_W / swirq_pkg::BYTE_W,
    localparam int unsigned NUM_REGS = NUM_FLAGS / LANES,
    localparam int unsigned IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [IDX_W-1:0]     wr_idx,
    input logic [DATA_W-1:0]    wr_data,
    input logic [LANES-1:0]     wr_strb,
    input logic [IDX_W-1:0]     rd_idx,
    input logic [DATA_W-1:0]    rd_data,
    input logic [NUM_FLAGS-1:0] irq_req
);
    import swirq_pkg::*;

    logic was_in_reset;
    // Remembers that the previous edge saw reset.
    always_ff @(posedge clk) was_in_reset <= !rst_n;

    // Checks the request lines right after a reset edge.
    always @(posedge clk) begin
        if (was_in_reset) begin
            assert_reset_clear_R1: assert (irq_req == '0)
                else $error("R1: irq_req not clear after reset");
        end
    end

    for (genvar n = 0; n < NUM_FLAGS; n++) begin : g_chk
        localparam int unsigned REG  = n / LANES;
        localparam int unsigned LANE = n % LANES;

        assert_raise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(REG) && wr_strb[LANE] && wr_data[LANE*BYTE_W+SET_POS])
            |=> irq_req[n]);

        assert_lower_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(REG) && wr_strb[LANE]
             && !wr_data[LANE*BYTE_W+SET_POS] && wr_data[LANE*BYTE_W+CLR_POS])
            |=> !irq_req[n]);

        assert_untouched_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == IDX_W'(REG) && wr_strb[LANE]
              && (wr_data[LANE*BYTE_W+SET_POS] || wr_data[LANE*BYTE_W+CLR_POS]))
            |=> $stable(irq_req[n]));

        assert_readback_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_idx == IDX_W'(REG)) |-> (rd_data[LANE*BYTE_W+CLR_POS] == irq_req[n]));
    end

    for (genvar l = 0; l < LANES; l++) begin : g_zero
        assert_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[l*BYTE_W +: CLR_POS] == '0);
    end
endmodule

bind swirq_flags swirq_flags_chk #(
    .NUM_FLAGS (NUM_FLAGS),
    .DATA_W    (DATA_W)
) chk_i (.*);

// File: tb/swirq_flags_tb_top.sv
// Bench: directed corners plus seeded random writes against a bench model.
module swirq_flags_tb_top;
    localparam int NF = 8;
    localparam int DW = 32;
    localparam int LN = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [0:0]    wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic [LN-1:0] wr_strb = '0;
    logic [0:0]    rd_idx = '0;
    logic [DW-1:0] rd_data;
    logic [NF-1:0] irq_req;

    logic [NF-1:0] model = '0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    swirq_flags dut_i (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_idx (wr_idx),
        .wr_data (wr_data), .wr_strb (wr_strb), .rd_idx (rd_idx),
        .rd_data (rd_data), .irq_req (irq_req)
    );

    // Model update: raise beats lower, strobe and index gate the lane.
    function automatic logic [NF-1:0] apply_write(logic [NF-1:0] f, logic en,
            logic idx, logic [DW-1:0] d, logic [LN-1:0] s);
        logic [NF-1:0] r = f;
        for (int n = 0; n < NF; n++) begin
            if (en && idx == 1'(n / LN) && s[n % LN]) begin
                if (d[(n % LN)*8 + 6]) r[n] = 1'b1;
                else if (d[(n % LN)*8 + 7]) r[n] = 1'b0;
            end
        end
        return r;
    endfunction

    // Expected read-back word.
    function automatic logic [DW-1:0] exp_read(logic [NF-1:0] f, logic idx);
        logic [DW-1:0] w = '0;
        for (int l = 0; l < LN; l++) w[l*8 + 7] = f[idx*LN + l];
        return w;
    endfunction

    task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compares request lines and both read-back words with the model.
    task automatic check_all(string tag);
        check(irq_req == model, {tag, " R9 irq"}, DW'(irq_req), DW'(model));
        for (int i = 0; i < 2; i++) begin
            rd_idx = 1'(i);
            #1;
            check(rd_data == exp_read(model, 1'(i)), {tag, " R8 read"},
                  rd_data, exp_read(model, 1'(i)));
        end
    endtask

    task automatic do_write(logic en, logic idx, logic [DW-1:0] d, logic [LN-1:0] s);
        @(negedge clk);
        wr_en = en; wr_idx = idx; wr_data = d; wr_strb = s;
        @(negedge clk);
        wr_en = 1'b0;
        model = apply_write(model, en, idx, d, s);
    endtask

    function automatic logic [7:0] pick_byte();
        case ($urandom % 5)
            0: return 8'h00;
            1: return 8'h40;
            2: return 8'h80;
            3: return 8'hC0;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(irq_req == '0, "R1 in reset", DW'(irq_req), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset");

        // R2: raise flag 5 (reg 1, lane 1)
        do_write(1, 1, 32'h0000_4000, 4'b0010);
        check(irq_req[5] == 1'b1, "R2 raise flag5", DW'(irq_req), DW'(model));
        check_all("R2");
        // R4: both bits with flag already set
        do_write(1, 1, 32'h0000_C000, 4'b0010);
        check(irq_req[5] == 1'b1, "R4 both when set", DW'(irq_req), DW'(model));
        // R3: lower flag 5
        do_write(1, 1, 32'h0000_8000, 4'b0010);
        check(irq_req[5] == 1'b0, "R3 lower flag5", DW'(irq_req), DW'(model));
        // R4: both bits with flag clear
        do_write(1, 0, 32'hC000_0000, 4'b1000);
        check(irq_req[3] == 1'b1, "R4 both when clear", DW'(irq_req), DW'(model));
        // R5: zeros leave flag 3 set
        do_write(1, 0, 32'h3F3F_3F3F, 4'b1111);
        check(irq_req == model, "R5 zero bits", DW'(irq_req), DW'(model));
        // R6: unstrobed lane ignored
        do_write(1, 0, 32'hC0C0_C0C0, 4'b0000);
        check(irq_req == model, "R6 no strobe", DW'(irq_req), DW'(model));
        // R7: write to reg 1 leaves reg 0 flag 3
        do_write(1, 1, 32'h8080_8080, 4'b1111);
        check(irq_req[3] == 1'b1, "R7 other register", DW'(irq_req), DW'(model));
        // R10: disabled write ignored
        do_write(0, 0, 32'h8080_8080, 4'b1111);
        check(irq_req[3] == 1'b1, "R10 wr_en low", DW'(irq_req), DW'(model));
        check_all("directed end");

        for (int k = 0; k < 300; k++) begin
            logic [DW-1:0] d;
            d = {pick_byte(), pick_byte(), pick_byte(), pick_byte()};
            do_write(($urandom % 8) != 0, 1'($urandom), d, 4'($urandom));
            check_all("random R2 R3 R4 R5 R6 R7 R10");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        done = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule